// File: doc/BRIEF.md
# Two-step dial combination lock

This block is a clocked state machine that releases a lock only after two dial operations arrive in the right order. Each operation is presented for one clock cycle with a valid strobe, a turn direction and a dial number. The block advances only on cycles where the strobe is high. A correct first operation followed directly by a correct second operation leads, one cycle later, to the open state.

The combination is fixed at build time through parameters: by default a right turn to 13, then a left turn to 22. A wrong operation while partly matched abandons the attempt. A relock pulse or a synchronous reset returns the lock to its idle state from anywhere. The outputs are an unlocked flag and the two-bit code of the current state.

Top module: `dial_lock`

## Requirements
- R1: While rst is high at a clock edge, the next state is idle: state_code reads 2'b00 and unlocked is low.
- R2: State codes are idle = 2'b00, first matched = 2'b01, both matched = 2'b10, open = 2'b11; direction bit 1 means right and 0 means left.
- R3: In idle, a strobed operation that equals the first combination step (default right, 13) moves the lock to first matched; any other strobed operation leaves it in idle.
- R4: In first matched, a strobed operation that equals the second combination step (default left, 22) moves the lock to both matched.
- R5: In first or both-matched-pending partial states (first matched), a strobed operation that matches neither step returns the lock to idle.
- R6: In first matched, a strobed operation equal to the first step keeps the lock in first matched, so a repeated first step restarts the attempt.
- R7: In idle and first matched, a cycle with the strobe low leaves the state unchanged.
- R8: From both matched the lock moves to open on the next clock edge, whatever the dial inputs are.
- R9: unlocked is high exactly when the state is open.
- R10: In open, dial operations have no effect; the lock stays open until relock or reset.
- R11: relock high at a clock edge returns the lock to idle from any state and takes priority over a simultaneous dial operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle strobe marking a dial operation |
| op_right | input | 1 | Turn direction of the operation: 1 right, 0 left |
| op_num | input | NUM_W | Dial number of the operation |
| relock | input | 1 | Returns the lock to idle |
| unlocked | output | 1 | High while the lock is open |
| state_code | output | 2 | Encoded current state |

## Verification
The bench builds the block with its default parameters: a 6-bit dial and the combination right 13 then left 22. Random dial numbers are drawn with a strong bias toward 13 and 22 and random directions, so reversed order, wrong direction, a repeated first step and operations inserted between the steps all occur often, and the open state is reached many times. Directed sequences cover relock racing a dial operation and operations presented while open.

// File: rtl/dial_lock.sv
module dial_lock #(
  parameter int          NUM_W     = 6,
  parameter bit          STEP1_RIGHT = 1'b1,
  parameter int unsigned STEP1_NUM = 13,
  parameter bit          STEP2_RIGHT = 1'b0,
  parameter int unsigned STEP2_NUM = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             op_right,
  input  logic [NUM_W-1:0] op_num,
  input  logic             relock,
  output logic             unlocked,
  output logic [1:0]       state_code
);
  localparam logic [1:0] S_IDLE = 2'b00;
  localparam logic [1:0] S_ONE  = 2'b01;
  localparam logic [1:0] S_TWO  = 2'b10;
  localparam logic [1:0] S_OPEN = 2'b11;
  localparam logic [NUM_W-1:0] K1 = NUM_W'(STEP1_NUM);
  localparam logic [NUM_W-1:0] K2 = NUM_W'(STEP2_NUM);

  logic [1:0] st, st_nx;
  logic hit1, hit2;

  assign hit1 = op_valid && (op_right == STEP1_RIGHT) && (op_num == K1);
  assign hit2 = op_valid && (op_right == STEP2_RIGHT) && (op_num == K2);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (op_valid) st_nx = hit1 ? S_ONE : S_IDLE;
      S_ONE:  if (op_valid) st_nx = hit2 ? S_TWO : (hit1 ? S_ONE : S_IDLE);
      S_TWO:  st_nx = S_OPEN;
      default: st_nx = S_OPEN;
    endcase
    if (relock) st_nx = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= st_nx;
  end

  assign state_code = st;
  assign unlocked   = (st == S_OPEN);
endmodule

module dial_lock_chk #(
  parameter int NUM_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic             op_right,
  input logic [NUM_W-1:0] op_num,
  input logic             relock,
  input logic             unlocked,
  input logic [1:0]       state_code
);
  p_rst_idle_r1: assert property (@(posedge clk) rst |=> state_code == 2'b00);
  p_unlock_open_r9: assert property (@(posedge clk) disable iff (rst)
    unlocked == (state_code == 2'b11));
  p_relock_idle_r11: assert property (@(posedge clk) disable iff (rst)
    relock |=> state_code == 2'b00);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !relock && !state_code[1]) |=> $stable(state_code));
  p_two_open_r8: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b10 && !relock) |=> state_code == 2'b11);
  p_open_stays_r10: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b11 && !relock) |=> state_code == 2'b11);
  p_idle_no_skip_r3: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b00) |=> !state_code[1]);
endmodule

bind dial_lock dial_lock_chk #(.NUM_W(NUM_W)) i_chk (.*);

// File: tb/test_dial_lock.sv
module test_dial_lock;
  localparam int W = 6;
  logic clk = 1'b0, rst = 1'b1, op_valid = 1'b0, op_right = 1'b0, relock = 1'b0;
  logic [W-1:0] op_num = '0;
  logic unlocked;
  logic [1:0] state_code;
  int checks = 0, errors = 0;
  logic [1:0] exp_st = 2'b00;
  bit done = 1'b0;

  dial_lock i_dial_lock (.clk(clk), .rst(rst), .op_valid(op_valid), .op_right(op_right),
    .op_num(op_num), .relock(relock), .unlocked(unlocked), .state_code(state_code));

  always #10 clk = ~clk;

  function automatic logic [1:0] model(logic [1:0] s, bit v, bit r, logic [W-1:0] n, bit rl);
    bit m1, m2;
    m1 = v && r && n == 6'd13;
    m2 = v && !r && n == 6'd22;
    if (rl) return 2'b00;
    case (s)
      2'b00: return (v && m1) ? 2'b01 : 2'b00;
      2'b01: return !v ? 2'b01 : (m2 ? 2'b10 : (m1 ? 2'b01 : 2'b00));
      default: return 2'b11;
    endcase
  endfunction

  task automatic check(string req);
    checks++;
    if (state_code !== exp_st || unlocked !== (exp_st == 2'b11)) begin
      errors++;
      $display("FAIL %s: state=%b unlocked=%b expected state=%b unlocked=%b",
               req, state_code, unlocked, exp_st, exp_st == 2'b11);
    end
  endtask

  task automatic cyc(bit v, bit r, int n, bit rl, string req);
    op_valid = v; op_right = r; op_num = W'(n); relock = rl;
    exp_st = model(exp_st, v, r, W'(n), rl);
    @(negedge clk);
    check(req);
    op_valid = 1'b0; relock = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: state=%b expected finish", state_code);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    exp_st = 2'b00; check("R1");
    rst = 1'b0;
    // correct sequence
    cyc(1, 1, 13, 0, "R3");
    cyc(0, 0, 0, 0, "R7");
    cyc(1, 0, 22, 0, "R4");
    cyc(1, 1, 13, 0, "R8");
    cyc(1, 1, 13, 0, "R10");
    cyc(1, 0, 22, 0, "R9");
    cyc(1, 1, 13, 1, "R11");
    // reversed order
    cyc(1, 0, 22, 0, "R3");
    cyc(1, 1, 13, 0, "R3");
    cyc(1, 1, 22, 0, "R5");
    // inserted operation
    cyc(1, 1, 13, 0, "R3");
    cyc(1, 0, 5, 0, "R5");
    cyc(1, 0, 22, 0, "R5");
    // repeated first step
    cyc(1, 1, 13, 0, "R3");
    cyc(1, 1, 13, 0, "R6");
    cyc(1, 0, 22, 0, "R4");
    cyc(0, 0, 0, 0, "R8");
    // relock racing a dial op in partial state
    cyc(1, 0, 0, 1, "R11");
    cyc(1, 1, 13, 0, "R3");
    cyc(1, 0, 22, 1, "R11");
    cyc(0, 0, 0, 0, "R7");
    // reset from open
    cyc(1, 1, 13, 0, "R3");
    cyc(1, 0, 22, 0, "R4");
    cyc(0, 0, 0, 0, "R2");
    rst = 1'b1; exp_st = 2'b00;
    @(negedge clk); check("R1");
    rst = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      int sel, n;
      sel = $urandom_range(0, 9);
      n = (sel < 4) ? 13 : (sel < 8) ? 22 : $urandom_range(0, 63);
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, n,
          $urandom_range(0, 40) == 0, "R5");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule